// File: doc/BRIEF.md
# Physical Address Cacheability Filter

This block sits after address translation and before the memory system. It takes one translated physical address per strobe, together with a flag that says whether the access is an instruction fetch. It returns the address as it must be presented to memory, an attribute that marks the access uncacheable and strictly ordered, and a two-bit fault code. The result appears one clock after the strobe. Instruction fetch and data access share the same path.

The input bus is wider than the implemented physical space. Any bit set above the implemented width is a machine check, and that check comes before all others. Within the implemented space, the top bit selects uncached I/O. For an I/O address the block looks for the internal-register hole. When the address is outside that hole, the block clears the intermediate address bits and raises the uncacheable attribute. An instruction fetch that lands in uncached space is refused, because reading a device register can destroy its contents. Bit positions and the register-hole decode are parameters.

Top module: `pa_cache_filter`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0, out_fault is 0, out_uncached is 0 and out_addr is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid high, and 0 otherwise. Each result belongs to the strobe one cycle earlier.
- R3: When any in_addr bit at or above IMPL_W (default bits 47:44) is set, the result has out_fault = 1 (machine check), out_uncached = 0 and out_addr equal to in_addr. This holds whatever the other bits and in_fetch are.
- R4: When no bit above IMPL_W is set and bit 43 is 0, the result has out_addr equal to in_addr, out_uncached = 0 and out_fault = 0.
- R5: When bit 43 is 1 and bits 42:40 are all 1, the result has out_fault = 2 (unimplemented register space), out_uncached = 0 and out_addr equal to in_addr. This applies to both fetch and data.
- R6: When bit 43 is 1 outside the register hole and in_fetch is 0, the result has out_uncached = 1, out_fault = 0, and out_addr equal to in_addr with bits 42:35 forced to 0.
- R7: When bit 43 is 1 outside the register hole and in_fetch is 1, the result has out_fault = 3 (uncached fetch), out_uncached = 1, and out_addr equal to in_addr with bits 42:35 forced to 0.
- R8: in_fetch does not change the result for cacheable addresses or for machine-check addresses.
- R9: In a cycle with in_valid low, in_addr and in_fetch have no effect. out_addr, out_uncached and out_fault keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | IN_W (48) | Translated physical address |
| in_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_addr | output | IN_W (48) | Adjusted physical address |
| out_uncached | output | 1 | Uncacheable and strictly ordered attribute |
| out_fault | output | 2 | 0 none, 1 machine check, 2 register space, 3 uncached fetch |

## Verification
The hardest situations to reach are the ones where several conditions hold at once. One is an address that sets an out-of-range bit and also the I/O bit and the register-hole bits. Another is an uncached fetch that must report both the cleared address and the fault. The stimulus builds these addresses on purpose and checks that the higher-priority outcome wins. It also sends back-to-back strobes, so that each result is tied to the strobe that produced it. Finally, it changes the address during idle cycles to show that the outputs hold.

// File: rtl/pacf_pkg.sv
package pacf_pkg;
  typedef enum logic [1:0] {
    PF_NONE   = 2'd0,
    PF_MCHK   = 2'd1,
    PF_REGSP  = 2'd2,
    PF_IFETCH = 2'd3
  } pf_code_t;
endpackage

// File: rtl/pacf_range_chk.sv
// Flags any address bit above the implemented physical width.
module pacf_range_chk #(
  parameter int IN_W   = 48,
  parameter int IMPL_W = 44
) (
  input  logic [IN_W-1:0] addr,
  output logic            over
);
  generate
    if (IN_W > IMPL_W) begin : g_hi
      assign over = |addr[IN_W-1:IMPL_W];
    end else begin : g_none
      assign over = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pacf_io_decode.sv
// Decodes the uncached I/O window and the internal-register hole, and
// builds the I/O form of the address with the intermediate bits cleared.
module pacf_io_decode #(
  parameter int IN_W   = 48,
  parameter int UNC_BIT = 43,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35,
  parameter int REG_HI = 42,
  parameter int REG_LO = 40
) (
  input  logic [IN_W-1:0] addr,
  output logic            io_space,
  output logic            reg_space,
  output logic [IN_W-1:0] io_addr
);
  assign io_space  = addr[UNC_BIT];
  assign reg_space = addr[UNC_BIT] & (&addr[REG_HI:REG_LO]);

  for (genvar i = 0; i < IN_W; i++) begin : g_bit
    if (i >= CLR_LO && i <= CLR_HI) begin : g_clr
      assign io_addr[i] = 1'b0;
    end else begin : g_keep
      assign io_addr[i] = addr[i];
    end
  end
endmodule

// File: rtl/pa_cache_filter.sv
module pa_cache_filter #(
  parameter int IN_W    = 48,
  parameter int IMPL_W  = 44,
  parameter int CLR_HI  = 42,
  parameter int CLR_LO  = 35,
  parameter int REG_HI  = 42,
  parameter int REG_LO  = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_addr,
  input  logic            in_fetch,
  output logic            out_valid,
  output logic [IN_W-1:0] out_addr,
  output logic            out_uncached,
  output logic [1:0]      out_fault
);
  import pacf_pkg::*;

  localparam int UNC_BIT = IMPL_W - 1;

  logic            over;
  logic            io_space;
  logic            reg_space;
  logic [IN_W-1:0] io_addr;

  pf_code_t        nx_fault;
  logic [IN_W-1:0] nx_addr;
  logic            nx_unc;

  pacf_range_chk #(.IN_W(IN_W), .IMPL_W(IMPL_W)) u_range (
    .addr (in_addr),
    .over (over)
  );

  pacf_io_decode #(
    .IN_W(IN_W), .UNC_BIT(UNC_BIT), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO),
    .REG_HI(REG_HI), .REG_LO(REG_LO)
  ) u_io (
    .addr      (in_addr),
    .io_space  (io_space),
    .reg_space (reg_space),
    .io_addr   (io_addr)
  );

  // Priority: range fault, then register hole, then I/O marking.
  always_comb begin
    nx_fault = PF_NONE;
    nx_addr  = in_addr;
    nx_unc   = 1'b0;
    if (over) begin
      nx_fault = PF_MCHK;
    end else if (reg_space) begin
      nx_fault = PF_REGSP;
    end else if (io_space) begin
      nx_addr  = io_addr;
      nx_unc   = 1'b1;
      nx_fault = in_fetch ? PF_IFETCH : PF_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_uncached <= 1'b0;
      out_fault    <= PF_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr     <= nx_addr;
        out_uncached <= nx_unc;
        out_fault    <= nx_fault;
      end
    end
  end
endmodule

// File: rtl/pacf_chk.sv
module pacf_chk #(
  parameter int IN_W   = 48,
  parameter int IMPL_W = 44,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [IN_W-1:0] out_addr,
  input logic            out_uncached,
  input logic [1:0]      out_fault
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_fault == 2'd0 && !out_uncached));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R6
  io_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_uncached) |-> (out_addr[CLR_HI:CLR_LO] == '0 && out_addr[IMPL_W-1]));
  // R3
  mchk_cached_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == 2'd1) |-> !out_uncached);
  // R7
  fetch_uncached_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == 2'd3) |-> out_uncached);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_addr) && $stable(out_fault) && $stable(out_uncached)));
endmodule

bind pa_cache_filter pacf_chk #(
  .IN_W(IN_W), .IMPL_W(IMPL_W), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_addr     (out_addr),
  .out_uncached (out_uncached),
  .out_fault    (out_fault)
);

// File: tb/sim_pa_cache_filter.sv
`timescale 1ns/1ps
module sim_pa_cache_filter;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_addr = '0;
  logic         in_fetch = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_addr;
  logic         out_uncached;
  logic [1:0]   out_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pa_cache_filter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_fetch(in_fetch), .out_valid(out_valid), .out_addr(out_addr),
    .out_uncached(out_uncached), .out_fault(out_fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected result computed from the requirements.
  task automatic model(input logic [W-1:0] a, input logic f,
                       output logic [W-1:0] ea, output logic eu, output logic [1:0] ef);
    ea = a; eu = 1'b0; ef = 2'd0;
    if (a[47:44] != 4'h0) ef = 2'd1;
    else if (a[43] && a[42:40] == 3'b111) ef = 2'd2;
    else if (a[43]) begin
      ea = a & ~(48'hFF << 35);
      eu = 1'b1;
      ef = f ? 2'd3 : 2'd0;
    end
  endtask

  task automatic check_out(input string req, input logic [W-1:0] a, input logic f);
    logic [W-1:0] ea; logic eu; logic [1:0] ef;
    model(a, f, ea, eu, ef);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " addr"}, 64'(out_addr), 64'(ea));
    chk({req, " uncached"}, 64'(out_uncached), 64'(eu));
    chk({req, " fault"}, 64'(out_fault), 64'(ef));
  endtask

  task automatic send(input string req, input logic [W-1:0] a, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_fetch = f;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req, a, f);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 64'(out_valid), 64'd0);
    chk("R1 fault", 64'(out_fault), 64'd0);
    chk("R1 uncached", 64'(out_uncached), 64'd0);
    chk("R1 addr", 64'(out_addr), 64'd0);
  endtask

  task automatic t_cacheable();
    send("R4 data", 48'h0123_4567_89A0, 1'b0);
    send("R4 low", 48'h0000_0000_0040, 1'b0);
    send("R8 fetch cacheable", 48'h07FF_FFFF_FFFC, 1'b1);
  endtask

  task automatic t_mchk();
    send("R3 bit44", 48'h1000_0000_0000, 1'b0);
    send("R3 over io+reg", 48'h8F00_0000_1234, 1'b0);
    send("R8 R3 fetch", 48'h2B00_0000_0010, 1'b1);
  endtask

  task automatic t_regspace();
    send("R5 data", 48'h0F00_0000_1234, 1'b0);
    send("R5 fetch", 48'h0FFF_FFFF_FFFF, 1'b1);
  endtask

  task automatic t_io();
    send("R6 data", 48'h0BFF_FFFF_FFFF, 1'b0);
    send("R6 edge", 48'h08FF_8000_0001, 1'b0);
    send("R7 fetch", 48'h0EAB_CDEF_1230, 1'b1);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    in_valid = 1'b1; in_addr = 48'h0A12_3456_7890; in_fetch = 1'b1;
    @(negedge clk);
    check_out("R2 first", 48'h0A12_3456_7890, 1'b1);
    in_addr = 48'h0012_3456_7890; in_fetch = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R2 second", 48'h0012_3456_7890, 1'b0);
    @(negedge clk);
    chk("R2 drop", 64'(out_valid), 64'd0);
  endtask

  task automatic t_hold();
    logic [W-1:0] ea; logic eu; logic [1:0] ef;
    send("R9 setup", 48'h0BFF_FFFF_FFFF, 1'b1);
    model(48'h0BFF_FFFF_FFFF, 1'b1, ea, eu, ef);
    in_addr = 48'hF000_0000_0000; in_fetch = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 valid", 64'(out_valid), 64'd0);
    chk("R9 addr", 64'(out_addr), 64'(ea));
    chk("R9 uncached", 64'(out_uncached), 64'(eu));
    chk("R9 fault", 64'(out_fault), 64'(ef));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_cacheable();
    t_mchk();
    t_regspace();
    t_io();
    t_b2b();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule